// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Byte

This block is the data path of a small accumulator-style controller. Each operation combines the working register and a file-register operand, or acts on the operand alone. The 8-bit result comes out combinationally, together with a combinational zero indication that a skip-if-zero decision can use. When the execute strobe is high at a clock edge, the carry and zero flags that the operation produces are written into a registered status byte.

The status byte keeps every field at a fixed bit position. Carry is bit 0, digit carry is bit 1, zero is bit 2, power-down is bit 3, watchdog timeout is bit 4, and page select is bits 7:5. This block never generates the upper five bits. It only holds them, and they change only through a whole-byte write port. The carry that the rotates consume is the carry bit stored in the status byte.

Top module: `alu8_core`

## Requirements
- R1: After reset `status_o` equals 8'h18, and it holds its value in any cycle where neither `exec_i` nor `st_wr_i` is high.
- R2: Opcodes 0, 1 and 2 give `res_o` = w AND f, w OR f and w XOR f respectively.
- R3: Opcode 3 gives the one's complement of f, and opcode 4 gives the one's complement of w.
- R4: Opcode 5 gives f+1 and opcode 6 gives f−1, both modulo 256.
- R5: Opcode 7 (rotate left through carry) gives {f[6:0], C}, and bit 0 of the status byte takes f[7]. Opcode 8 (rotate right through carry) gives {C, f[7:1]}, and bit 0 of the status byte takes f[0]. C is status bit 0 before the edge.
- R6: Opcode 9 gives f with bits 7:4 and 3:0 exchanged, and it leaves the status byte unchanged.
- R7: For opcodes 0–6, executing sets status bit 2 to 1 exactly when the result is 8'h00. `zero_o` shows the same test combinationally for every opcode.
- R8: Rotates change only status bit 0. Opcodes 0–6 change only status bit 2.
- R9: No operation changes status bits 7:3 or status bit 1.
- R10: Opcodes 10–15 pass f through to `res_o` and change no status bit.
- R11: `st_wr_i` loads `st_wdata_i` into the whole status byte at the next edge, and it takes precedence over `exec_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation select |
| w_i | input | 8 | Working register operand |
| f_i | input | 8 | File-register operand |
| exec_i | input | 1 | Commit the operation's flags at this edge |
| st_wr_i | input | 1 | Load the whole status byte |
| st_wdata_i | input | 8 | Status load value |
| res_o | output | 8 | Combinational result |
| zero_o | output | 1 | Result equals zero (combinational) |
| status_o | output | 8 | Registered status byte |

## Verification
The bench builds the block with its default 8-bit width, which is small enough to sweep every operand value. For every opcode and every f in 0..255, it runs with the carry both clear and set, pairs f with a varied w, and presets the upper status bits to a changing pattern. This covers all-ones and all-zeros wrap for increment and decrement, the carry entering and leaving at both ends of each rotate, and proof that the held fields survive every operation. Separate cases cover the reset value, idle hold, and a status load that collides with an execute.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  parameter int DW  = 8;
  localparam int NIB = DW / 2;

  // status bit positions
  localparam int ST_C  = 0;
  localparam int ST_DC = 1;
  localparam int ST_Z  = 2;

  localparam logic [3:0] OP_AND  = 4'd0;
  localparam logic [3:0] OP_OR   = 4'd1;
  localparam logic [3:0] OP_XOR  = 4'd2;
  localparam logic [3:0] OP_COMF = 4'd3;
  localparam logic [3:0] OP_COMW = 4'd4;
  localparam logic [3:0] OP_INC  = 4'd5;
  localparam logic [3:0] OP_DEC  = 4'd6;
  localparam logic [3:0] OP_RLC  = 4'd7;
  localparam logic [3:0] OP_RRC  = 4'd8;
  localparam logic [3:0] OP_SWAP = 4'd9;

  function automatic logic [DW-1:0] nib_swap(input logic [DW-1:0] v);
    return {v[NIB-1:0], v[DW-1:NIB]};
  endfunction

  function automatic logic [DW:0] rot_left_c(input logic [DW-1:0] v, input logic c);
    // {carry_out, result}
    return {v, c};
  endfunction

  function automatic logic [DW:0] rot_right_c(input logic [DW-1:0] v, input logic c);
    // {carry_out, result}
    return {v[0], c, v[DW-1:1]};
  endfunction

  function automatic logic zflag_op(input logic [3:0] op);
    return op <= OP_DEC;
  endfunction
endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] w_i,
  input  logic [DW-1:0] f_i,
  output logic [DW-1:0] res_o,
  output logic          hit_o
);
  always_comb begin
    hit_o = 1'b1;
    unique case (op_i)
      OP_AND:  res_o = w_i & f_i;
      OP_OR:   res_o = w_i | f_i;
      OP_XOR:  res_o = w_i ^ f_i;
      OP_COMF: res_o = ~f_i;
      OP_COMW: res_o = ~w_i;
      OP_SWAP: res_o = nib_swap(f_i);
      default: begin
        res_o = f_i;
        hit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] f_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          hit_o,
  output logic          rot_o
);
  logic [DW:0] rl, rr;
  assign rl = rot_left_c(f_i, cin_i);
  assign rr = rot_right_c(f_i, cin_i);

  always_comb begin
    hit_o  = 1'b1;
    rot_o  = 1'b0;
    cout_o = cin_i;
    unique case (op_i)
      OP_INC: res_o = f_i + 1'b1;
      OP_DEC: res_o = f_i - 1'b1;
      OP_RLC: begin
        res_o = rl[DW-1:0]; cout_o = rl[DW]; rot_o = 1'b1;
      end
      OP_RRC: begin
        res_o = rr[DW-1:0]; cout_o = rr[DW]; rot_o = 1'b1;
      end
      default: begin
        res_o = f_i;
        hit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status #(
  parameter logic [7:0] RST_VAL = 8'h18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       upd_c_i,
  input  logic       new_c_i,
  input  logic       upd_z_i,
  input  logic       new_z_i,
  output logic [7:0] q_o
);
  localparam int C_POS = alu8_pkg::ST_C;
  localparam int Z_POS = alu8_pkg::ST_Z;

  for (genvar b = 0; b < 8; b++) begin : g_bit
    logic nxt;
    always_comb begin
      nxt = q_o[b];
      if (wr_i) nxt = wdata_i[b];
      else if (b == C_POS && upd_c_i) nxt = new_c_i;
      else if (b == Z_POS && upd_z_i) nxt = new_z_i;
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q_o[b] <= RST_VAL[b];
      else        q_o[b] <= nxt;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter logic [7:0] RST_STATUS = 8'h18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] w_i,
  input  logic [DW-1:0] f_i,
  input  logic          exec_i,
  input  logic          st_wr_i,
  input  logic [7:0]    st_wdata_i,
  output logic [DW-1:0] res_o,
  output logic          zero_o,
  output logic [7:0]    status_o
);
  logic [DW-1:0] lg_res, ar_res;
  logic          lg_hit, ar_hit, ar_rot, ar_cout;
  logic          carry_in;
  // named events for the checker
  logic          res_zero, upd_c, upd_z;

  assign carry_in = status_o[ST_C];

  alu8_logic u_logic (
    .op_i(op_i), .w_i(w_i), .f_i(f_i), .res_o(lg_res), .hit_o(lg_hit)
  );

  alu8_arith u_arith (
    .op_i(op_i), .f_i(f_i), .cin_i(carry_in),
    .res_o(ar_res), .cout_o(ar_cout), .hit_o(ar_hit), .rot_o(ar_rot)
  );

  always_comb begin
    if (lg_hit)      res_o = lg_res;
    else if (ar_hit) res_o = ar_res;
    else             res_o = f_i;
  end

  assign res_zero = (res_o == '0);
  assign zero_o   = res_zero;
  assign upd_c    = exec_i & ar_rot;
  assign upd_z    = exec_i & zflag_op(op_i);

  alu8_status #(.RST_VAL(RST_STATUS)) u_status (
    .clk(clk), .rst_n(rst_n),
    .wr_i(st_wr_i), .wdata_i(st_wdata_i),
    .upd_c_i(upd_c), .new_c_i(ar_cout),
    .upd_z_i(upd_z), .new_z_i(res_zero),
    .q_o(status_o)
  );
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_i,
  input logic [7:0] f_i,
  input logic       exec_i,
  input logic       st_wr_i,
  input logic [7:0] st_wdata_i,
  input logic [7:0] res_o,
  input logic [7:0] status_o
);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i && !st_wr_i) |=> $stable(status_o));
  // R5
  rlc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !st_wr_i && op_i == 4'd7) |=> status_o[0] == $past(f_i[7]));
  // R5
  rrc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !st_wr_i && op_i == 4'd8) |=> status_o[0] == $past(f_i[0]));
  // R6
  swap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !st_wr_i && op_i == 4'd9) |=> $stable(status_o));
  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !st_wr_i && op_i <= 4'd6) |=> status_o[2] == ($past(res_o) == 8'h00));
  // R9
  held_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr_i) |=> (status_o[7:3] == $past(status_o[7:3]) && status_o[1] == $past(status_o[1])));
  // R10
  spare_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !st_wr_i && op_i >= 4'd10) |=> $stable(status_o));
  // R11
  st_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_i |=> status_o == $past(st_wdata_i));
endmodule

bind alu8_core alu8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .f_i(f_i), .exec_i(exec_i),
  .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i), .res_o(res_o), .status_o(status_o)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] w = '0, f = '0, wd = '0;
  logic       ex = 1'b0, wr = 1'b0;
  logic [7:0] res, st;
  logic       zr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op), .w_i(w), .f_i(f),
    .exec_i(ex), .st_wr_i(wr), .st_wdata_i(wd),
    .res_o(res), .zero_o(zr), .status_o(st)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d w=%h f=%h actual=%h expected=%h", req, op, w, f, act, exp);
    end
  endtask

  function automatic string req_of(input int o);
    case (o)
      0, 1, 2: return "R2";
      3, 4:    return "R3";
      5, 6:    return "R4";
      7, 8:    return "R5";
      9:       return "R6";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_r, exp_s, pre;
    logic       c;
    repeat (3) @(negedge clk);
    chk("R1", st, 8'h18);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", st, 8'h18);

    // load colliding with execute: load wins
    wd = 8'hA5; wr = 1'b1; ex = 1'b1; op = 4'd7; f = 8'h00;
    @(negedge clk); wr = 1'b0; ex = 1'b0;
    chk("R11", st, 8'hA5);
    @(negedge clk); @(negedge clk);
    chk("R1", st, 8'hA5);

    for (int o = 0; o < 11; o++) begin
      for (int fv = 0; fv < 256; fv++) begin
        for (int ci = 0; ci < 2; ci++) begin
          f   = fv[7:0];
          w   = 8'(fv * 53 + o * 17 + ci * 91);
          c   = ci[0];
          pre = {w[7:1] ^ 7'h4B, c};
          wd = pre; wr = 1'b1; ex = 1'b0;
          @(negedge clk); wr = 1'b0;
          case (o)
            0: exp_r = w & f;
            1: exp_r = w | f;
            2: exp_r = w ^ f;
            3: exp_r = 8'hFF - f;
            4: exp_r = 8'hFF - w;
            5: exp_r = 8'((fv + 1) % 256);
            6: exp_r = 8'((fv + 255) % 256);
            7: exp_r = 8'((fv * 2) % 256 + ci);
            8: exp_r = 8'(fv / 2 + ci * 128);
            9: exp_r = 8'((fv % 16) * 16 + fv / 16);
            default: exp_r = f;
          endcase
          exp_s = pre;
          if (o <= 6) exp_s[2] = (exp_r == 8'h00);
          if (o == 7) exp_s[0] = f[7];
          if (o == 8) exp_s[0] = f[0];
          op = (o == 10) ? 4'(10 + fv % 6) : 4'(o);
          ex = 1'b1;
          #1;
          chk(req_of(o), res, exp_r);
          checks++;
          if (zr !== (exp_r == 8'h00)) begin
            errors++;
            $display("FAIL R7 zero_o actual=%b expected=%b", zr, exp_r == 8'h00);
          end
          @(negedge clk); ex = 1'b0;
          if (o <= 6) chk("R7", st, exp_s);
          else if (o <= 8) chk("R8", st, exp_s);
          else chk(req_of(o), st, exp_s);
          chk("R9", {st[7:3], 2'b00, st[1]}, {pre[7:3], 2'b00, pre[1]});
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule